// File: doc/BRIEF.md
# Translation Buffer with Global-Entry Flush Control

This block is a small fully associative translation cache for 4 KB pages. It holds virtual page numbers, the physical frame numbers they map to, and a per-entry global flag. A combinational lookup port reports hit or miss in the same cycle. On a hit it returns the physical address, built from the stored frame number and the untranslated low 12 bits of the virtual address. After a miss, a fill port installs a translation. The fill uses the lowest-numbered empty slot if there is one, and otherwise replaces the least recently used entry. Recency is kept as a saturating age counter on each entry.

There are two classes of invalidation. An address-space-switch pulse removes only the entries whose global flag is clear. Four other sources cause a full flush that removes every entry, global ones included: a paging-control change, a paging-mode setting change, a memory-type range register write, and either edge of an external flush pin. A privilege change has no input and invalidates nothing. The block contains no walker, no permission checks and no large-page support.

Top module: `tlb_gflush`

## Requirements
- R1: `lk_hit` is 1 only when `lk_valid` is 1 and a valid entry's page number equals `lk_vaddr[31:12]`. On a hit, `lk_paddr` is the stored frame number concatenated with `lk_vaddr[11:0]`; otherwise `lk_paddr` is 0. After reset no entry is valid.
- R2: A fill (`fill_valid` = 1) is visible to lookups from the next cycle. If its page number is already present, that entry's frame number and global flag are overwritten in place, so no duplicate is created.
- R3: A fill of a new page number uses the lowest-index empty slot while any slot is empty.
- R4: When every slot is valid, a fill of a new page number replaces the entry with the largest age. Ties go to the lowest index. In each cycle with a hit or a fill, the used entries' ages become 0 and every other valid entry's age increases by one, saturating at 2^AGE_W-1.
- R5: An `asid_switch` pulse invalidates every entry whose global flag is 0. Global entries and their ages are unchanged.
- R6: A pulse on `paging_chg`, `mode_chg` or `range_wr`, or any change of `flush_pin` from its value in the previous cycle, invalidates every entry, global ones included.
- R7: In a cycle where any invalidation is triggered, the lookup reports a miss, a fill is discarded, and no age changes except through the flush itself.
- R8: A lookup hit refreshes the entry's recency, so the next replacement does not evict an entry that was just looked up while an older entry exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_paddr | output | PA_W | Translated physical address, 0 on miss |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VA_W-12 | Virtual page number to install |
| fill_pfn | input | PA_W-12 | Physical frame number to install |
| fill_global | input | 1 | Global flag of the new entry |
| asid_switch | input | 1 | Address-space switch: drop non-global entries |
| paging_chg | input | 1 | Paging or protection enable changed: full flush |
| mode_chg | input | 1 | Page-size, global-enable or address-extension setting changed: full flush |
| range_wr | input | 1 | Memory-type range register written: full flush |
| flush_pin | input | 1 | External flush level; either edge causes a full flush |

## Verification
On every cycle, the assertions check three things: global entries survive an address-space switch while all non-global entries are gone, every full-flush source leaves the buffer empty, and no hit is reported while a flush is triggered. They also check that matches are never duplicated and that occupancy never shrinks without a flush. The correct choice of victim, the age ordering after mixed hits and fills, in-place overwrite, and frame-number passthrough can only be shown by the bench scenarios. In those scenarios a behavioural model predicts the result of every lookup and sweeps of probe lookups expose which entries survived.

// File: rtl/tlb_gflush_pkg.sv
// Package: shared constants and the invalidation-class type of the
// translation buffer. Assumes 4 KB pages only.
package tlb_gflush_pkg;
    localparam int unsigned PG_OFS_W = 12;

    typedef enum logic [1:0] {
        FL_NONE  = 2'd0,
        FL_LOCAL = 2'd1,
        FL_ALL   = 2'd2
    } flush_e;
endpackage

// File: rtl/tlb_flush_ctl.sv
// Flush controller: merges the invalidation triggers into one class per cycle.
// Assumes every trigger except flush_pin is a one-cycle pulse. flush_pin is a
// level, and each of its edges counts as a full-flush request. A full flush
// overrides a selective one.
module tlb_flush_ctl
    import tlb_gflush_pkg::*;
(
    input  logic   clk,
    input  logic   asid_switch,
    input  logic   paging_chg,
    input  logic   mode_chg,
    input  logic   range_wr,
    input  logic   flush_pin,
    output flush_e flush_kind
);
    logic pin_q;
    logic full_req;

    // Remember the previous pin level for edge detection (reset-independent).
    always_ff @(posedge clk) begin
        pin_q <= flush_pin;
    end

    // Pick the strongest invalidation class requested this cycle.
    always_comb begin
        full_req = paging_chg | mode_chg | range_wr | (flush_pin ^ pin_q);
        if (full_req)
            flush_kind = FL_ALL;
        else if (asid_switch)
            flush_kind = FL_LOCAL;
        else
            flush_kind = FL_NONE;
    end
endmodule

// File: rtl/tlb_cam_match.sv
// Tag comparator: one equality compare per entry against a single key.
// Assumes entry tags are unique while valid, so at most one bit is set.
module tlb_cam_match #(
    parameter int unsigned N     = 8,
    parameter int unsigned TAG_W = 20
) (
    input  logic [N-1:0]     valid,
    input  logic [TAG_W-1:0] tags [N],
    input  logic [TAG_W-1:0] key,
    output logic [N-1:0]     match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        // Compare one entry's tag with the key.
        assign match[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/tlb_victim.sv
// Replacement selector: returns the lowest-index empty slot if one exists,
// otherwise the slot with the largest age, with ties going to the lowest
// index. Assumes N >= 2.
module tlb_victim #(
    parameter int unsigned N     = 8,
    parameter int unsigned AGE_W = 8,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic [AGE_W-1:0] age [N],
    output logic [IDX_W-1:0] idx
);
    logic             found_empty;
    logic [AGE_W-1:0] best_age;

    // Scan for an empty slot first, then for the oldest entry.
    always_comb begin
        found_empty = 1'b0;
        idx         = '0;
        best_age    = age[0];
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !found_empty) begin
                found_empty = 1'b1;
                idx         = IDX_W'(i);
            end
        end
        if (!found_empty) begin
            for (int i = 1; i < N; i++) begin
                if (age[i] > best_age) begin
                    best_age = age[i];
                    idx      = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/tlb_gflush.sv
// Translation buffer top: fully associative, 4 KB pages, a global flag on
// each entry, and replacement by age-counter LRU. Lookup is combinational.
// Fills, flushes and age updates take effect at the clock edge. Assumes
// ENTRIES >= 2 and that a fill follows a miss. A fill of a page that is
// already present overwrites that entry in place.
module tlb_gflush
    import tlb_gflush_pkg::*;
#(
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PA_W    = 32,
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned AGE_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [VA_W-1:0]          lk_vaddr,
    output logic                     lk_hit,
    output logic [PA_W-1:0]          lk_paddr,
    input  logic                     fill_valid,
    input  logic [VA_W-PG_OFS_W-1:0] fill_vpn,
    input  logic [PA_W-PG_OFS_W-1:0] fill_pfn,
    input  logic                     fill_global,
    input  logic                     asid_switch,
    input  logic                     paging_chg,
    input  logic                     mode_chg,
    input  logic                     range_wr,
    input  logic                     flush_pin
);
    localparam int unsigned VPN_W   = VA_W - PG_OFS_W;
    localparam int unsigned PFN_W   = PA_W - PG_OFS_W;
    localparam int unsigned IDX_W   = $clog2(ENTRIES);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] glob_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [AGE_W-1:0]   age_q [ENTRIES];

    flush_e             flush_kind;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fill_match;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   fill_idx;
    logic [ENTRIES-1:0] use_vec;
    logic               fill_do;
    logic [PFN_W-1:0]   hit_pfn;

    tlb_flush_ctl u_flush (
        .clk         (clk),
        .asid_switch (asid_switch),
        .paging_chg  (paging_chg),
        .mode_chg    (mode_chg),
        .range_wr    (range_wr),
        .flush_pin   (flush_pin),
        .flush_kind  (flush_kind)
    );

    tlb_cam_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_cam (
        .valid (valid_q),
        .tags  (vpn_q),
        .key   (lk_vaddr[VA_W-1:PG_OFS_W]),
        .match (lk_match)
    );

    tlb_cam_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_fill_cam (
        .valid (valid_q),
        .tags  (vpn_q),
        .key   (fill_vpn),
        .match (fill_match)
    );

    tlb_victim #(.N(ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_victim (
        .valid (valid_q),
        .age   (age_q),
        .idx   (victim_idx)
    );

    // Lookup result: a hit is suppressed in any cycle that carries a flush.
    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i])
                hit_pfn = hit_pfn | pfn_q[i];
        end
        lk_hit   = lk_valid && (|lk_match) && (flush_kind == FL_NONE);
        lk_paddr = lk_hit ? {hit_pfn, lk_vaddr[PG_OFS_W-1:0]} : '0;
    end

    // Fill slot: overwrite an existing match in place, else take the victim.
    always_comb begin
        fill_do  = fill_valid && (flush_kind == FL_NONE);
        fill_idx = victim_idx;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_match[i])
                fill_idx = IDX_W'(i);
        end
        use_vec = lk_hit ? lk_match : '0;
        if (fill_do)
            use_vec[fill_idx] = 1'b1;
    end

    // Entry state: apply a flush, or else a fill and the age update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            glob_q  <= '0;
            for (int i = 0; i < ENTRIES; i++)
                age_q[i] <= '0;
        end else begin
            case (flush_kind)
                FL_ALL:   valid_q <= '0;
                FL_LOCAL: valid_q <= valid_q & glob_q;
                default: begin
                    if (fill_do) begin
                        valid_q[fill_idx] <= 1'b1;
                        glob_q[fill_idx]  <= fill_global;
                        vpn_q[fill_idx]   <= fill_vpn;
                        pfn_q[fill_idx]   <= fill_pfn;
                    end
                    if (|use_vec) begin
                        for (int i = 0; i < ENTRIES; i++) begin
                            if (use_vec[i])
                                age_q[i] <= '0;
                            else if (valid_q[i] && age_q[i] != AGE_MAX)
                                age_q[i] <= age_q[i] + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tlb_gflush_chk.sv
// Checker: temporal properties of the translation buffer, attached by bind.
// Assumes the same ENTRIES as the bound instance.
module tlb_gflush_chk
    import tlb_gflush_pkg::*;
#(
    parameter int unsigned ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               lk_hit,
    input logic               asid_switch,
    input logic               paging_chg,
    input logic               mode_chg,
    input logic               range_wr,
    input logic               flush_pin,
    input flush_e             flush_kind,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] glob_q,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] fill_match
);
    // R1
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

    // R2
    no_dup_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(fill_match));

    // R3
    no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_kind == FL_NONE) |=> $countones(valid_q) >= $past($countones(valid_q)));

    // R5
    local_drops_nonglobal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asid_switch && !paging_chg && !mode_chg && !range_wr && flush_pin == $past(flush_pin))
        |=> ((valid_q & ~glob_q) == '0) && ((valid_q & glob_q) == $past(valid_q & glob_q)));

    // R6
    full_sources_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paging_chg || mode_chg || range_wr) |=> valid_q == '0);

    // R6
    pin_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_pin != $past(flush_pin)) |=> valid_q == '0);

    // R7
    flush_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asid_switch || paging_chg || mode_chg || range_wr) |-> !lk_hit);
endmodule

bind tlb_gflush tlb_gflush_chk #(.ENTRIES(ENTRIES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_hit      (lk_hit),
    .asid_switch (asid_switch),
    .paging_chg  (paging_chg),
    .mode_chg    (mode_chg),
    .range_wr    (range_wr),
    .flush_pin   (flush_pin),
    .flush_kind  (flush_kind),
    .valid_q     (valid_q),
    .glob_q      (glob_q),
    .lk_match    (lk_match),
    .fill_match  (fill_match)
);

// File: tb/tlb_gflush_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural model predicts each lookup and is compared every cycle.
module tlb_gflush_tb_top;
    localparam int N       = 8;
    localparam int AGE_MAX = 255;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_pfn;
    logic        fill_global;
    logic        asid_switch, paging_chg, mode_chg, range_wr, flush_pin;

    int  n_cmp = 0, n_bad = 0;
    bit  done = 0;

    bit  m_valid [N];
    bit  m_glob  [N];
    int  m_vpn   [N];
    int  m_pfn   [N];
    int  m_age   [N];
    bit  m_pin_prev;

    always #2 clk = ~clk;

    tlb_gflush dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_global(fill_global), .asid_switch(asid_switch), .paging_chg(paging_chg),
        .mode_chg(mode_chg), .range_wr(range_wr), .flush_pin(flush_pin)
    );

    task automatic idle();
        lk_valid = 0; lk_vaddr = '0; fill_valid = 0; fill_vpn = '0; fill_pfn = '0;
        fill_global = 0; asid_switch = 0; paging_chg = 0; mode_chg = 0; range_wr = 0;
    endtask

    // One cycle: compare the lookup outputs, then advance the model at the edge.
    task automatic cycle(string req);
        bit full, any_fl, e_hit, used[N], any_used;
        int e_pa, hi, fi, best;
        #1;
        full   = paging_chg || mode_chg || range_wr || (flush_pin != m_pin_prev);
        any_fl = full || asid_switch;
        e_hit = 0; e_pa = 0; hi = -1;
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == int'(lk_vaddr[31:12])) hi = i;
        if (lk_valid && hi >= 0 && !any_fl) begin
            e_hit = 1; e_pa = (m_pfn[hi] << 12) | int'(lk_vaddr[11:0]);
        end
        if (rst_n) begin
            n_cmp++;
            if (lk_hit !== e_hit) begin
                n_bad++;
                $display("FAIL %s: lk_hit=%0b expected %0b (va %h)", req, lk_hit, e_hit, lk_vaddr);
            end
            n_cmp++;
            if (lk_paddr !== 32'(e_pa)) begin
                n_bad++;
                $display("FAIL %s: lk_paddr=%h expected %h", req, lk_paddr, 32'(e_pa));
            end
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_glob[i] = 0; m_age[i] = 0; end
        end else if (full) begin
            for (int i = 0; i < N; i++) m_valid[i] = 0;
        end else if (asid_switch) begin
            for (int i = 0; i < N; i++) if (!m_glob[i]) m_valid[i] = 0;
        end else begin
            for (int i = 0; i < N; i++) used[i] = 0;
            if (e_hit) used[hi] = 1;
            fi = -1;
            if (fill_valid) begin
                for (int i = 0; i < N; i++)
                    if (m_valid[i] && m_vpn[i] == int'(fill_vpn)) fi = i;
                if (fi < 0)
                    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) fi = i;
                if (fi < 0) begin
                    fi = 0; best = m_age[0];
                    for (int i = 1; i < N; i++) if (m_age[i] > best) begin best = m_age[i]; fi = i; end
                end
                used[fi] = 1;
            end
            any_used = 0;
            for (int i = 0; i < N; i++) any_used |= used[i];
            if (any_used)
                for (int i = 0; i < N; i++) begin
                    if (used[i]) m_age[i] = 0;
                    else if (m_valid[i] && m_age[i] < AGE_MAX) m_age[i]++;
                end
            if (fi >= 0) begin
                m_valid[fi] = 1; m_glob[fi] = fill_global;
                m_vpn[fi] = int'(fill_vpn); m_pfn[fi] = int'(fill_pfn);
            end
        end
        m_pin_prev = flush_pin;
        @(negedge clk);
        idle();
    endtask

    task automatic look(int vpn, int ofs, string req);
        lk_valid = 1; lk_vaddr = {20'(vpn), 12'(ofs)};
        cycle(req);
    endtask

    task automatic fill(int vpn, int pfn, bit g, string req);
        fill_valid = 1; fill_vpn = 20'(vpn); fill_pfn = 20'(pfn); fill_global = g;
        cycle(req);
    endtask

    task automatic sweep(int lo, int cnt, string req);
        for (int k = 0; k < cnt; k++) look(lo + k, k * 37, req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: cycles exhausted, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(); flush_pin = 0; rst_n = 0; m_pin_prev = 0;
        @(negedge clk);
        repeat (3) cycle("R1");
        rst_n = 1;
        look(16'h0123, 12'h456, "R1");               // reset state: miss
        fill(20'h12345, 20'hABCDE, 0, "R2");
        look(20'h12345, 12'h678, "R1");              // hit, offset passes through
        lk_vaddr = 32'h12345678; cycle("R1");        // no request, no hit
        fill(20'h12345, 20'h55555, 1, "R2");         // overwrite in place
        look(20'h12345, 12'hFFF, "R2");
        for (int k = 1; k < 8; k++) fill(16'h100 + k, 16'h700 + k, k[0], "R3");
        sweep(16'h100, 8, "R3");
        look(20'h12345, 12'h001, "R3");
        // all eight full: new fills evict the oldest
        fill(16'h200, 16'h900, 0, "R4");
        fill(16'h201, 16'h901, 0, "R4");
        sweep(16'h100, 8, "R4"); sweep(16'h200, 2, "R4"); look(20'h12345, 0, "R4");
        // refresh one entry, then fill: refreshed entry must survive
        look(16'h107, 12'h010, "R8");
        fill(16'h202, 16'h902, 1, "R8");
        look(16'h107, 12'h020, "R8"); sweep(16'h100, 8, "R8"); sweep(16'h200, 3, "R8");
        // flush in the same cycle as a lookup and a fill
        lk_valid = 1; lk_vaddr = {20'h00202, 12'h0}; fill_valid = 1; fill_vpn = 20'h00300;
        fill_pfn = 20'h00333; asid_switch = 1; cycle("R7");
        look(16'h300, 0, "R7");
        sweep(16'h100, 8, "R5"); sweep(16'h200, 3, "R5"); look(20'h12345, 0, "R5");
        // each full-flush source
        for (int s = 0; s < 5; s++) begin
            fill(16'h400 + s, 16'hA00 + s, 1, "R6");
            fill(16'h410 + s, 16'hB00 + s, 0, "R6");
            case (s)
                0: paging_chg = 1;
                1: mode_chg = 1;
                2: range_wr = 1;
                3: flush_pin = 1;
                default: flush_pin = 0;
            endcase
            lk_valid = 1; lk_vaddr = {20'(16'h400 + s), 12'h0}; cycle("R6");
            look(16'h400 + s, 0, "R6"); look(16'h410 + s, 0, "R6");
        end
        // mixed traffic over a small page pool
        for (int k = 0; k < 2000; k++) begin
            int r = int'($urandom_range(0, 99));
            lk_valid = ($urandom_range(0, 3) != 0);
            lk_vaddr = {20'($urandom_range(0, 13)), 12'($urandom_range(0, 4095))};
            if (r < 40) begin
                fill_valid = 1; fill_vpn = 20'($urandom_range(0, 13));
                fill_pfn = 20'($urandom); fill_global = $urandom_range(0, 1) == 1;
            end
            if (r == 97) asid_switch = 1;
            if (r == 98) range_wr = 1;
            if (r == 99) flush_pin = ~flush_pin;
            cycle("R4");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule